// File: doc/BRIEF.md
# Transmit DMA Channel

This block is the sending half of a packet network interface. Software describes a frame in memory through four small registers: a negative word count, a word-aligned buffer address, a start delay, and a control/status word. Setting the enable bit clears the previous status and starts a countdown. The countdown moves one step per `tick` pulse, so software can hold back a retry by a chosen amount after a collision.

When the countdown reaches zero, the channel reads 16-bit words from memory over a request/grant port. Each word goes into a one-word staging buffer. The serial side pulls words from that buffer with a request pulse. Words pass through unchanged, so software must write any header fields, the sender's own address included, into the buffer itself.

A transfer ends in one of three ways:
- **Completion.** This raises the normal interrupt.
- **Collision.** This raises a separate collision interrupt.
- **Underrun.** The serial side asks for a word that is not ready. This sets the error bit and raises neither interrupt.

Top module: `tx_dma_chan`

## Requirements
- R1: After reset every register reads zero, and `mem_req`, `ser_valid`, `irq_done` and `irq_col` are low.
- R2: Register offsets (`reg_addr`) are as follows:
  - 0: word count. Bits 9..0 hold the count and bits 15..10 read zero.
  - 1: buffer address. Bit 0 always reads zero.
  - 2: control/status. Error is bit 15, Done bit 7, Interrupt Enable bit 6 and Enable bit 0.
  - 3: start delay. Bits 7..0 are kept and the upper bits read zero.
  - Reads are combinational.
- R3: Writing offset 2 with bit 0 set clears Done and Error and sets Enable. No memory request is made until the start delay has been counted down to zero by `tick` pulses.
- R4: `mem_req` is high only while running, with the staging buffer empty and the count nonzero. Each granted cycle captures `mem_rdata`, adds one to the count and adds 2 to the address.
- R5: A `ser_req` pulse while a word is staged produces `ser_valid` one cycle later. `ser_data` then equals the memory word exactly as fetched.
- R6: When the count is zero and the staging buffer is empty, Done is set and Enable clears. A count of zero therefore completes without any memory request.
- R7: A `ser_req` pulse while running with nothing staged and a nonzero count sets Error, clears Enable and stops the transfer.
- R8: `col_in` while running sets Error, clears Enable and stops the transfer. A collision takes priority over completion and underrun in the same cycle.
- R9: `irq_done` is high while Done and Interrupt Enable are set and the transfer did not end in a collision.
- R10: `irq_col` is high while Error from a collision and Interrupt Enable are both set. Error from an underrun never raises it.
- R11: Writes to the count, address and delay registers are ignored while Enable is set.
- R12: Writing offset 2 with bit 0 clear drops Enable and aborts any pending or running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_gnt | input | 1 | Grant; read data is valid in the same cycle |
| mem_rdata | input | 16 | Memory read data |
| tick | input | 1 | Start-delay countdown pulse |
| ser_req | input | 1 | Serial side asks for the next word |
| col_in | input | 1 | Collision seen on the line |
| ser_valid | output | 1 | Word presented on ser_data |
| ser_data | output | 16 | Word sent to the serial side |
| irq_done | output | 1 | Completion interrupt |
| irq_col | output | 1 | Collision interrupt |

## Verification
Register reads and `mem_req` are combinational. The bench samples them at the falling edge in the same cycle as the state they reflect. Status bits and both interrupts change at the first rising edge after the causing `ser_req`, `col_in` or countdown event, and `ser_valid` with its data also follows `ser_req` by exactly one rising edge. The bench therefore drives every stimulus at a falling edge and reads the result at least one falling edge later. The delay check samples `mem_req` just before and two edges after the last needed `tick`, which brackets the cycle in which fetching may begin.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;

    localparam logic [1:0] OFS_COUNT = 2'd0;
    localparam logic [1:0] OFS_ADDR  = 2'd1;
    localparam logic [1:0] OFS_CTRL  = 2'd2;
    localparam logic [1:0] OFS_DELAY = 2'd3;

    localparam int BIT_ERR  = 15;
    localparam int BIT_DONE = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_EN   = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic err;
        logic done;
        logic ie;
        logic en;
    } ctrl_t;

    function automatic logic [15:0] pack_ctrl(ctrl_t c);
        logic [15:0] v;
        v = '0;
        v[BIT_ERR]  = c.err;
        v[BIT_DONE] = c.done;
        v[BIT_IE]   = c.ie;
        v[BIT_EN]   = c.en;
        return v;
    endfunction

endpackage

// File: rtl/tx_dma_delay.sv
module tx_dma_delay #(
    parameter int DLYW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [DLYW-1:0] load_val,
    input  logic            active,
    input  logic            tick,
    output logic            zero
);
    logic [DLYW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (active && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/tx_dma_fetch.sv
module tx_dma_fetch #(
    parameter int AW  = 16,
    parameter int WCW = 10,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cnt_we,
    input  logic [WCW-1:0] cnt_wdata,
    input  logic           adr_we,
    input  logic [AW-1:1]  adr_wdata,
    input  logic           clr,
    input  logic           running,
    input  logic           take,
    input  logic           mem_gnt,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic [WCW-1:0] count,
    output logic           cnt_zero,
    output logic [DW-1:0]  stage,
    output logic           stage_full
);
    logic [WCW-1:0] cnt_q;
    logic [AW-1:1]  wadr_q;
    logic [DW-1:0]  stage_q;
    logic           full_q;
    logic           fetch;

    assign cnt_zero = (cnt_q == '0);
    assign mem_req  = running && !full_q && !cnt_zero;
    assign fetch    = mem_req && mem_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            wadr_q  <= '0;
            stage_q <= '0;
            full_q  <= 1'b0;
        end else begin
            if (cnt_we) begin
                cnt_q <= cnt_wdata;
            end else if (fetch) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (adr_we) begin
                wadr_q <= adr_wdata;
            end else if (fetch) begin
                wadr_q <= wadr_q + 1'b1;
            end
            if (clr) begin
                full_q <= 1'b0;
            end else if (fetch) begin
                full_q  <= 1'b1;
                stage_q <= mem_rdata;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    assign mem_addr   = {wadr_q, 1'b0};
    assign count      = cnt_q;
    assign stage      = stage_q;
    assign stage_full = full_q;
endmodule

// File: rtl/tx_dma_chan.sv
module tx_dma_chan
    import tx_dma_pkg::*;
#(
    parameter int AW   = 16,
    parameter int WCW  = 10,
    parameter int DLYW = 8,
    parameter int DW   = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    input  logic          tick,
    input  logic          ser_req,
    input  logic          col_in,
    output logic          ser_valid,
    output logic [DW-1:0] ser_data,
    output logic          irq_done,
    output logic          irq_col
);
    tx_state_e       st_q;
    ctrl_t           ctl_q;
    logic            col_q;
    logic [DLYW-1:0] dly_q;
    logic            ser_valid_q;
    logic [DW-1:0]   ser_data_q;

    logic            wr_ctrl, start, running, idle_regs;
    logic            dly_zero, take, finish, underrun;
    logic [WCW-1:0]  count;
    logic            cnt_zero, stage_full;
    logic [DW-1:0]   stage;

    assign wr_ctrl   = reg_wr && reg_addr == OFS_CTRL;
    assign start     = wr_ctrl && reg_wdata[BIT_EN];
    assign running   = (st_q == ST_RUN);
    assign idle_regs = !ctl_q.en;
    assign take      = running && ser_req && stage_full;
    assign finish    = running && cnt_zero && !stage_full;
    assign underrun  = running && ser_req && !stage_full && !cnt_zero;

    tx_dma_delay #(.DLYW(DLYW)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (dly_q),
        .active   (st_q == ST_WAIT),
        .tick     (tick),
        .zero     (dly_zero)
    );

    tx_dma_fetch #(.AW(AW), .WCW(WCW), .DW(DW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .cnt_we     (reg_wr && reg_addr == OFS_COUNT && idle_regs),
        .cnt_wdata  (reg_wdata[WCW-1:0]),
        .adr_we     (reg_wr && reg_addr == OFS_ADDR && idle_regs),
        .adr_wdata  (reg_wdata[AW-1:1]),
        .clr        (start),
        .running    (running),
        .take       (take),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .count      (count),
        .cnt_zero   (cnt_zero),
        .stage      (stage),
        .stage_full (stage_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
        end else if (reg_wr && reg_addr == OFS_DELAY && idle_regs) begin
            dly_q <= reg_wdata[DLYW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ctl_q <= '0;
            col_q <= 1'b0;
        end else if (start) begin
            st_q     <= ST_WAIT;
            ctl_q.en <= 1'b1;
            ctl_q.ie <= reg_wdata[BIT_IE];
            ctl_q.done <= 1'b0;
            ctl_q.err  <= 1'b0;
            col_q    <= 1'b0;
        end else if (wr_ctrl) begin
            st_q     <= ST_IDLE;
            ctl_q.en <= 1'b0;
            ctl_q.ie <= reg_wdata[BIT_IE];
        end else begin
            case (st_q)
                ST_WAIT: if (dly_zero) st_q <= ST_RUN;
                ST_RUN: begin
                    if (col_in) begin
                        ctl_q.err <= 1'b1;
                        ctl_q.en  <= 1'b0;
                        col_q     <= 1'b1;
                        st_q      <= ST_IDLE;
                    end else if (finish) begin
                        ctl_q.done <= 1'b1;
                        ctl_q.en   <= 1'b0;
                        st_q       <= ST_IDLE;
                    end else if (underrun) begin
                        ctl_q.err <= 1'b1;
                        ctl_q.en  <= 1'b0;
                        st_q      <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_valid_q <= 1'b0;
            ser_data_q  <= '0;
        end else begin
            ser_valid_q <= take;
            if (take) ser_data_q <= stage;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_COUNT: reg_rdata[WCW-1:0]  = count;
            OFS_ADDR:  reg_rdata[AW-1:0]   = mem_addr;
            OFS_CTRL:  reg_rdata           = pack_ctrl(ctl_q);
            default:   reg_rdata[DLYW-1:0] = dly_q;
        endcase
    end

    assign ser_valid = ser_valid_q;
    assign ser_data  = ser_data_q;
    assign irq_done  = ctl_q.done && ctl_q.ie && !col_q;
    assign irq_col   = ctl_q.err && col_q && ctl_q.ie;
endmodule

// File: rtl/tx_dma_chan_chk.sv
module tx_dma_chan_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        mem_gnt,
    input logic        ser_req,
    input logic        ser_valid,
    input logic        irq_done,
    input logic        irq_col,
    input logic        col_in,
    input logic [15:0] reg_rdata,
    input logic [1:0]  reg_addr
);
    AST_REQ_WHEN_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && reg_addr == 2'd2) |-> reg_rdata[0]); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=> mem_addr == $past(mem_addr) + 16'd2); // R4
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        ser_valid |-> $past(ser_req)); // R5
    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(irq_done && irq_col)); // R9
    AST_COL_IRQ_NEEDS_COL: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_col) |-> $past(col_in)); // R10
    AST_NO_REQ_AFTER_COL: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_col) |-> !mem_req); // R8
endmodule

bind tx_dma_chan tx_dma_chan_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_gnt   (mem_gnt),
    .ser_req   (ser_req),
    .ser_valid (ser_valid),
    .irq_done  (irq_done),
    .irq_col   (irq_col),
    .col_in    (col_in),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr)
);

// File: tb/tx_dma_chan_tb.sv
module tx_dma_chan_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_req, mem_gnt;
    logic [15:0] mem_addr, mem_rdata;
    logic        tick = 1'b0, ser_req = 1'b0, col_in = 1'b0;
    logic        ser_valid;
    logic [15:0] ser_data;
    logic        irq_done, irq_col;
    logic        gnt_allow = 1'b1;
    logic        req_seen = 1'b0;

    int tests = 0;
    int fails = 0;
    logic [15:0] expq[$];

    always #2 clk = ~clk;

    function automatic logic [15:0] memw(logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    assign mem_gnt   = mem_req & gnt_allow;
    assign mem_rdata = memw(mem_addr);

    tx_dma_chan u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .tick(tick), .ser_req(ser_req), .col_in(col_in),
        .ser_valid(ser_valid), .ser_data(ser_data),
        .irq_done(irq_done), .irq_col(irq_col)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference scoreboard: every presented word must be the next expected one (R5)
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) req_seen = 1'b1;
            if (ser_valid) begin
                if (expq.size() == 0) begin
                    check("R5 unexpected word", ser_data, 16'hxxxx);
                end else begin
                    check("R5 word data", ser_data, expq.pop_front());
                end
            end
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk); ser_req = 1'b1;
        @(negedge clk); ser_req = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        cyc(3);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); check("R1 count", v, 16'h0000);
        rd(2'd1, v); check("R1 addr", v, 16'h0000);
        rd(2'd2, v); check("R1 ctrl", v, 16'h0000);
        rd(2'd3, v); check("R1 delay", v, 16'h0000);
        check("R1 outputs", {12'd0, mem_req, ser_valid, irq_done, irq_col}, 16'h0);

        // R2 field masking
        wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R2 count mask", v, 16'h03FF);
        wr(2'd1, 16'h1235); rd(2'd1, v); check("R2 addr bit0", v, 16'h1234);
        wr(2'd3, 16'hAB07); rd(2'd3, v); check("R2 delay mask", v, 16'h0007);

        // R3 start delay: 3 ticks before any fetch
        gnt_allow = 1'b0;
        wr(2'd3, 16'h0003);
        wr(2'd0, 16'h03FF);
        wr(2'd2, 16'h0001);
        for (int t = 0; t < 2; t++) begin
            cyc(2); tick = 1'b1; @(negedge clk); tick = 1'b0;
        end
        cyc(3);
        check("R3 no req during delay", {15'd0, mem_req}, 16'h0);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        cyc(2);
        check("R3 req after delay", {15'd0, mem_req}, 16'h1);
        // R12 abort
        wr(2'd2, 16'h0000);
        @(negedge clk);
        check("R12 abort stops req", {15'd0, mem_req}, 16'h0);
        rd(2'd2, v); check("R12 enable cleared", v, 16'h0000);
        gnt_allow = 1'b1;

        // R4 R5 R6 R9 normal four-word transfer with interrupt enable
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h03FC);
        wr(2'd1, 16'h0100);
        for (int k = 0; k < 4; k++) expq.push_back(memw(16'h0100 + 16'(2*k)));
        wr(2'd2, 16'h0041);
        cyc(3);
        for (int k = 0; k < 4; k++) begin pulse_req(); cyc(2); end
        cyc(2);
        check("R5 all words sent", 16'(expq.size()), 16'h0);
        rd(2'd2, v); check("R6 done set", v, 16'h00C0);
        rd(2'd0, v); check("R4 count at zero", v, 16'h0000);
        rd(2'd1, v); check("R4 addr advanced", v, 16'h0108);
        check("R9 irq_done", {14'd0, irq_done, irq_col}, 16'h2);

        // R3 restart clears done; R6 zero count completes without request; IE off
        req_seen = 1'b0;
        wr(2'd2, 16'h0001);
        cyc(4);
        rd(2'd2, v); check("R6 zero count done", v, 16'h0080);
        check("R6 no request", {15'd0, req_seen}, 16'h0);
        check("R9 irq masked", {14'd0, irq_done, irq_col}, 16'h0);

        // R8 R10 R11 collision mid-transfer
        wr(2'd0, 16'h03F8);
        wr(2'd1, 16'h0200);
        wr(2'd2, 16'h0041);
        cyc(4);
        wr(2'd0, 16'h0155);
        wr(2'd1, 16'h0400);
        wr(2'd3, 16'h0009);
        rd(2'd0, v); check("R11 count write ignored", v, 16'h03F9);
        rd(2'd1, v); check("R11 addr write ignored", v, 16'h0202);
        rd(2'd3, v); check("R11 delay write ignored", v, 16'h0000);
        @(negedge clk); col_in = 1'b1; @(negedge clk); col_in = 1'b0;
        cyc(1);
        rd(2'd2, v); check("R8 collision error", v, 16'h8040);
        check("R10 irq_col", {14'd0, irq_done, irq_col}, 16'h1);
        check("R8 fetch stopped", {15'd0, mem_req}, 16'h0);

        // R7 R10 underrun: no grant, serial asks
        gnt_allow = 1'b0;
        wr(2'd0, 16'h03FE);
        wr(2'd2, 16'h0041);
        rd(2'd2, v); check("R3 restart clears error", v, 16'h0041);
        cyc(3);
        pulse_req();
        cyc(2);
        rd(2'd2, v); check("R7 underrun error", v, 16'h8040);
        check("R10 no col irq on underrun", {14'd0, irq_done, irq_col}, 16'h0);
        check("R7 fetch stopped", {15'd0, mem_req}, 16'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule